// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block turns a single block-transfer command into a series of word-sized memory accesses, one for each register selected in a 16-bit register mask. It sits between an instruction decoder, the register file and a data-memory port. A command carries the mask, a starting base address and four control bits: load or store, step-before or step-after, increment or decrement, and base writeback. The sequencer walks the mask, steps the address by one word per access, and reports when the whole transfer is finished.

For stores it reads each selected register through a register-file read port and sends the value to memory. For loads it waits for each read response and writes the returned word into the register file. It also produces a base-register writeback value. A load into the highest register, which is the program counter, also produces a branch request. A command that combines step-after with the writeback bit is flagged as illegal but is still carried out in step-after form.

Top module: `blk_xfer_seq`

## Requirements
- R1: A command is taken only in a cycle where both `cmd_valid_i` and `cmd_ready_o` are high. `cmd_ready_o` is high only while the block is idle. While it is idle, no request, register write, base write or done pulse appears, and a command offered while the block is busy is ignored.
- R2: Bit i of the mask selects register i. Clear bits are skipped, and each set bit produces exactly one memory request. A load serves the set bits from the highest index down to the lowest. A store serves them from the lowest index up to the highest.
- R3: The address moves by +4 when the increment bit is 1 and by −4 when it is 0. In step-before mode each request uses the address after its step. In step-after mode each request uses the address before its step, so the first request goes to the base.
- R4: Each step happens in the cycle its request is accepted. In that cycle `base_we_o` is raised with the stepped address on `base_wdata_o`, in step-after mode always and in step-before mode only when the writeback bit is 1.
- R5: A store request has `mem_we_o`=1, `mem_wstrb_o`=4'b1111 and `mem_wdata_o` equal to the register-file value at `rf_raddr_o`, which is the index being served. A load request has `mem_we_o`=0 and `mem_wstrb_o`=4'b0000.
- R6: When a load response arrives, `rf_we_o` writes `mem_rdata_i` to the index being served. If that index is 15, `branch_valid_o` is raised in the same cycle with `branch_target_o` equal to the loaded word.
- R7: A command accepted with step-after mode and writeback bit 1 raises `err_o` for one cycle, the cycle after acceptance. The transfer still runs as a normal step-after transfer.
- R8: A request stays valid, with an unchanged address, until it is accepted. After a load request is accepted, no further request is issued until its response has returned.
- R9: `done_o` is a one-cycle pulse. It comes in the cycle after the last store is accepted or after the last load response arrives. An empty mask raises `done_o` in the cycle after acceptance and issues no request.
- R10: `mem_rvalid_i` is ignored unless a load response is awaited. At any other time it causes no register write and no branch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_list_i | input | NREG | Register selection mask |
| cmd_base_i | input | AW | Starting base address |
| cmd_load_i | input | 1 | 1 = load, 0 = store |
| cmd_pre_i | input | 1 | 1 = step before access, 0 = after |
| cmd_up_i | input | 1 | 1 = increment, 0 = decrement |
| cmd_wb_i | input | 1 | Base writeback request |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_addr_o | output | AW | Request address |
| mem_we_o | output | 1 | Request is a write |
| mem_wstrb_o | output | DW/8 | Byte strobes |
| mem_wdata_o | output | DW | Write data |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | DW | Read response data |
| rf_raddr_o | output | log2(NREG) | Register read index |
| rf_rdata_i | input | DW | Register read data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | log2(NREG) | Register write index |
| rf_wdata_o | output | DW | Register write data |
| base_we_o | output | 1 | Base writeback enable |
| base_wdata_o | output | AW | Base writeback value |
| branch_valid_o | output | 1 | Program counter was loaded |
| branch_target_o | output | DW | Branch target |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Illegal mode combination pulse |

## Verification
When register 15 is loaded, the register-file write and the branch request fall in the same cycle. Because a load walks downward, this happens on the very first response of any load whose mask has bit 15 set. The bench provokes it with directed and random masks that include bit 15. In that cycle it checks that the branch target equals the word the memory model returned for the first address, and that a write to index 15 is present in the same cycle. In the same way, the base writeback coincides with request acceptance under randomly stalled `mem_req_ready_i`, and the bench checks each writeback value against the step sequence it computes itself.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_RWAIT = 2'd2,
    ST_FIN   = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic load;
    logic pre;
    logic up;
    logic wb;
  } xfer_mode_t;

endpackage

// File: rtl/blk_xfer_pick.sv
// Selects the next register index from the pending mask.
module blk_xfer_pick #(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend_i,
  input  logic            desc_i,
  output logic [IW-1:0]   idx_o,
  output logic            last_o
);

  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pend_i[i]) lo_idx = IW'(i);
    end
    for (int i = 0; i < NREG; i++) begin
      if (pend_i[i]) hi_idx = IW'(i);
    end
  end

  assign idx_o  = desc_i ? hi_idx : lo_idx;
  assign last_o = (pend_i != '0) && ((pend_i & (pend_i - NREG'(1))) == '0);

endmodule

// File: rtl/blk_xfer_addr.sv
// Running address with one-word step per accepted request.
module blk_xfer_addr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] base_i,
  input  logic          up_i,
  input  logic          pre_i,
  input  logic          adv_i,
  output logic [AW-1:0] acc_addr_o,
  output logic [AW-1:0] nxt_addr_o
);

  logic [AW-1:0] cur_q;

  assign nxt_addr_o = up_i ? cur_q + AW'(STEP) : cur_q - AW'(STEP);
  assign acc_addr_o = pre_i ? nxt_addr_o : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cur_q <= '0;
    else if (cap_i) cur_q <= base_i;
    else if (adv_i) cur_q <= nxt_addr_o;
  end

endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [NREG-1:0] cmd_list_i,
  input  xfer_mode_t      cmd_mode_i,
  output logic            cmd_ready_o,
  output logic            cmd_fire_o,
  output xfer_mode_t      mode_o,
  output logic [NREG-1:0] pend_o,
  input  logic [IW-1:0]   cur_idx_i,
  input  logic            last_i,
  input  logic            req_fire_i,
  input  logic            rvalid_i,
  output logic            req_valid_o,
  output logic            rwait_o,
  output logic [IW-1:0]   ld_idx_o,
  output logic            done_o,
  output logic            err_o
);

  seq_st_e         st_q, st_d;
  xfer_mode_t      mode_q;
  logic [NREG-1:0] pend_q;
  logic [IW-1:0]   ld_idx_q;
  logic            err_q;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign cmd_fire_o  = cmd_valid_i & cmd_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (cmd_fire_o) st_d = (cmd_list_i == '0) ? ST_FIN : ST_REQ;
      ST_REQ:   if (req_fire_i) st_d = mode_q.load ? ST_RWAIT : (last_i ? ST_FIN : ST_REQ);
      ST_RWAIT: if (rvalid_i)   st_d = (pend_q == '0) ? ST_FIN : ST_REQ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mode_q   <= '0;
      pend_q   <= '0;
      ld_idx_q <= '0;
      err_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= cmd_fire_o & ~cmd_mode_i.pre & cmd_mode_i.wb;
      if (cmd_fire_o) begin
        mode_q <= cmd_mode_i;
        pend_q <= cmd_list_i;
      end else if (req_fire_i) begin
        pend_q   <= pend_q & ~(NREG'(1) << cur_idx_i);
        ld_idx_q <= cur_idx_i;
      end
    end
  end

  assign mode_o      = mode_q;
  assign pend_o      = pend_q;
  assign req_valid_o = (st_q == ST_REQ);
  assign rwait_o     = (st_q == ST_RWAIT);
  assign ld_idx_o    = ld_idx_q;
  assign done_o      = (st_q == ST_FIN);
  assign err_o       = err_q;

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  output logic                    cmd_ready_o,
  input  logic [NREG-1:0]         cmd_list_i,
  input  logic [AW-1:0]           cmd_base_i,
  input  logic                    cmd_load_i,
  input  logic                    cmd_pre_i,
  input  logic                    cmd_up_i,
  input  logic                    cmd_wb_i,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [AW-1:0]           mem_addr_o,
  output logic                    mem_we_o,
  output logic [DW/8-1:0]         mem_wstrb_o,
  output logic [DW-1:0]           mem_wdata_o,
  input  logic                    mem_rvalid_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic [$clog2(NREG)-1:0] rf_raddr_o,
  input  logic [DW-1:0]           rf_rdata_i,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [DW-1:0]           rf_wdata_o,
  output logic                    base_we_o,
  output logic [AW-1:0]           base_wdata_o,
  output logic                    branch_valid_o,
  output logic [DW-1:0]           branch_target_o,
  output logic                    done_o,
  output logic                    err_o
);

  localparam int IW     = $clog2(NREG);
  localparam int STEP   = DW / 8;
  localparam int PC_IDX = NREG - 1;

  xfer_mode_t      cmd_mode;
  xfer_mode_t      mode;
  logic            cmd_fire;
  logic [NREG-1:0] pend;
  logic [IW-1:0]   cur_idx;
  logic [IW-1:0]   ld_idx;
  logic            last;
  logic            req_valid;
  logic            req_fire;
  logic            rwait;
  logic            rsp_fire;
  logic [AW-1:0]   acc_addr;
  logic [AW-1:0]   nxt_addr;

  assign cmd_mode = '{load: cmd_load_i, pre: cmd_pre_i, up: cmd_up_i, wb: cmd_wb_i};

  blk_xfer_ctrl #(.NREG(NREG), .IW(IW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_list_i  (cmd_list_i),
    .cmd_mode_i  (cmd_mode),
    .cmd_ready_o (cmd_ready_o),
    .cmd_fire_o  (cmd_fire),
    .mode_o      (mode),
    .pend_o      (pend),
    .cur_idx_i   (cur_idx),
    .last_i      (last),
    .req_fire_i  (req_fire),
    .rvalid_i    (mem_rvalid_i),
    .req_valid_o (req_valid),
    .rwait_o     (rwait),
    .ld_idx_o    (ld_idx),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  blk_xfer_pick #(.NREG(NREG), .IW(IW)) u_pick (
    .pend_i (pend),
    .desc_i (mode.load),
    .idx_o  (cur_idx),
    .last_o (last)
  );

  blk_xfer_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cmd_fire),
    .base_i     (cmd_base_i),
    .up_i       (mode.up),
    .pre_i      (mode.pre),
    .adv_i      (req_fire),
    .acc_addr_o (acc_addr),
    .nxt_addr_o (nxt_addr)
  );

  assign req_fire = req_valid & mem_req_ready_i;
  assign rsp_fire = rwait & mem_rvalid_i;

  assign mem_req_valid_o = req_valid;
  assign mem_addr_o      = acc_addr;
  assign mem_we_o        = req_valid & ~mode.load;
  assign mem_wstrb_o     = mem_we_o ? '1 : '0;
  assign mem_wdata_o     = mem_we_o ? rf_rdata_i : '0;
  assign rf_raddr_o      = cur_idx;

  assign base_we_o    = req_fire & (~mode.pre | mode.wb);
  assign base_wdata_o = nxt_addr;

  assign rf_we_o    = rsp_fire;
  assign rf_waddr_o = ld_idx;
  assign rf_wdata_o = mem_rdata_i;

  assign branch_valid_o  = rsp_fire & (ld_idx == IW'(PC_IDX));
  assign branch_target_o = mem_rdata_i;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cmd_valid_i,
  input logic                    cmd_ready_o,
  input logic [NREG-1:0]         cmd_list_i,
  input logic                    cmd_pre_i,
  input logic                    cmd_wb_i,
  input logic                    mem_req_valid_o,
  input logic                    mem_req_ready_i,
  input logic [AW-1:0]           mem_addr_o,
  input logic                    mem_we_o,
  input logic [DW/8-1:0]         mem_wstrb_o,
  input logic                    rf_we_o,
  input logic [$clog2(NREG)-1:0] rf_waddr_o,
  input logic [DW-1:0]           rf_wdata_o,
  input logic                    base_we_o,
  input logic                    branch_valid_o,
  input logic [DW-1:0]           branch_target_o,
  input logic                    done_o,
  input logic                    err_o
);

  localparam int IW = $clog2(NREG);

  p_busy_after_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_req_valid_o && !base_we_o && !done_o);

  p_base_on_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_o |-> mem_req_valid_o && mem_req_ready_i);

  p_strobes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_we_o ? (mem_wstrb_o == '1) : (mem_wstrb_o == '0)));

  p_branch_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_valid_o |-> rf_we_o && (rf_waddr_o == IW'(NREG - 1)) && (branch_target_o == rf_wdata_o));

  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i && cmd_ready_o && !cmd_pre_i && cmd_wb_i));

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && cmd_ready_o);

  p_empty_list_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && (cmd_list_i == '0) |=> done_o && !mem_req_valid_o);

  p_rsp_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !rf_we_o && !branch_valid_o);

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [15:0] cmd_list_i = '0;
  logic [31:0] cmd_base_i = '0;
  logic        cmd_load_i = 1'b0;
  logic        cmd_pre_i = 1'b0;
  logic        cmd_up_i = 1'b0;
  logic        cmd_wb_i = 1'b0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_we_o;
  logic [3:0]  mem_wstrb_o;
  logic [31:0] mem_wdata_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  rf_raddr_o;
  logic [31:0] rf_rdata_i;
  logic        rf_we_o;
  logic [3:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        base_we_o;
  logic [31:0] base_wdata_o;
  logic        branch_valid_o;
  logic [31:0] branch_target_o;
  logic        done_o;
  logic        err_o;

  logic [31:0] rf_model [16];
  assign rf_rdata_i = rf_model[rf_raddr_o];

  blk_xfer_seq dut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // monitor state and logs
  logic [31:0] lg_addr [16];
  logic        lg_we [16];
  logic [3:0]  lg_strb [16];
  logic [31:0] lg_wdata [16];
  logic [3:0]  lg_ridx [16];
  logic [31:0] lg_rdat [16];
  logic [31:0] lg_base [16];
  int n_req, n_rfw, n_base, n_br, n_done, n_err, done_pc;
  int n_overlap, n_holdbad, n_idleact;
  logic [31:0] br_tgt;
  logic        br_pair;
  int          rd_cnt = 0;
  logic [31:0] rd_addr = '0;
  bit          spur = 1'b0;
  int          pcyc = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  event        mon_ev;

  always @(posedge clk_i) pcyc++;

  task automatic clear_logs();
    n_req = 0; n_rfw = 0; n_base = 0; n_br = 0; n_done = 0; n_err = 0;
    done_pc = -1; n_overlap = 0; n_holdbad = 0; n_idleact = 0;
    br_tgt = '0; br_pair = 1'b0;
  endtask

  always @(negedge clk_i) begin
    mem_rvalid_i = 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_fn(rd_addr);
      end
    end
    if (spur) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = 32'hDEAD_BEEF;
    end
    mem_req_ready_i = ($urandom % 4) != 0;
    #1;
    if (cmd_ready_o && (mem_req_valid_o || rf_we_o || base_we_o || done_o)) n_idleact++;
    if (mem_req_valid_o) begin
      if (rd_cnt > 0 || (mem_rvalid_i && !spur)) n_overlap++;
      if (prev_stall && mem_addr_o != prev_addr) n_holdbad++;
    end else if (prev_stall) n_holdbad++;
    prev_stall = mem_req_valid_o && !mem_req_ready_i;
    prev_addr  = mem_addr_o;
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (n_req < 16) begin
        lg_addr[n_req]  = mem_addr_o;
        lg_we[n_req]    = mem_we_o;
        lg_strb[n_req]  = mem_wstrb_o;
        lg_wdata[n_req] = mem_wdata_o;
      end
      n_req++;
      if (!mem_we_o) begin
        rd_cnt  = 1 + int'($urandom % 3);
        rd_addr = mem_addr_o;
      end
    end
    if (rf_we_o) begin
      if (n_rfw < 16) begin
        lg_ridx[n_rfw] = rf_waddr_o;
        lg_rdat[n_rfw] = rf_wdata_o;
      end
      n_rfw++;
    end
    if (base_we_o) begin
      if (n_base < 16) lg_base[n_base] = base_wdata_o;
      n_base++;
    end
    if (branch_valid_o) begin
      n_br++;
      br_tgt  = branch_target_o;
      br_pair = rf_we_o && (rf_waddr_o == 4'd15);
    end
    if (done_o) begin
      n_done++;
      done_pc = pcyc;
    end
    if (err_o) n_err++;
    ->mon_ev;
  end

  task automatic run_cmd(input logic [15:0] lst, input logic [31:0] base,
                         input bit ld, input bit pre, input bit up, input bit wb,
                         input bit junk);
    logic [31:0] e_addr [16];
    int          e_idx [16];
    logic [31:0] e_base [16];
    logic [31:0] a, nxt;
    int n, nb, k0, guard, idx;
    bit exp_br;
    for (int i = 0; i < 16; i++) rf_model[i] = $urandom;
    clear_logs();
    n = 0; nb = 0; a = base;
    for (int i = 0; i < 16; i++) begin
      idx = ld ? 15 - i : i;
      if (lst[idx]) begin
        nxt = up ? a + 32'd4 : a - 32'd4;
        e_addr[n] = pre ? nxt : a;
        e_idx[n]  = idx;
        if (!pre || wb) begin
          e_base[nb] = nxt;
          nb++;
        end
        a = nxt;
        n++;
      end
    end
    @(negedge clk_i);
    cmd_list_i = lst; cmd_base_i = base; cmd_load_i = ld;
    cmd_pre_i = pre; cmd_up_i = up; cmd_wb_i = wb; cmd_valid_i = 1'b1;
    k0 = pcyc;
    @(negedge clk_i);
    if (junk) begin
      cmd_list_i = 16'hFFFF; cmd_load_i = ~ld; cmd_base_i = 32'h0000_0100;
    end else cmd_valid_i = 1'b0;
    guard = 0;
    while (n_done == 0 && guard < 400) begin
      @(mon_ev);
      guard++;
    end
    cmd_valid_i = 1'b0;
    @(mon_ev);
    chk(n_done == 1, $sformatf("R9 done count act=%0d exp=1", n_done));
    chk(cmd_ready_o == 1'b1, $sformatf("R1 ready after done act=%0b exp=1", cmd_ready_o));
    chk(n_idleact == 0, $sformatf("R1 idle activity act=%0d exp=0", n_idleact));
    chk(n_req == n, $sformatf("R2 request count act=%0d exp=%0d", n_req, n));
    for (int k = 0; k < n && k < n_req; k++) begin
      chk(lg_addr[k] == e_addr[k], $sformatf("R3 addr[%0d] act=%h exp=%h", k, lg_addr[k], e_addr[k]));
      chk(lg_we[k] == !ld && lg_strb[k] == (ld ? 4'h0 : 4'hF),
          $sformatf("R5 we/strb[%0d] act=%0b/%h exp=%0b/%h", k, lg_we[k], lg_strb[k], !ld, ld ? 4'h0 : 4'hF));
      if (!ld)
        chk(lg_wdata[k] == rf_model[e_idx[k]],
            $sformatf("R2 store data[%0d] act=%h exp=%h", k, lg_wdata[k], rf_model[e_idx[k]]));
    end
    if (ld) begin
      chk(n_rfw == n, $sformatf("R6 reg write count act=%0d exp=%0d", n_rfw, n));
      for (int k = 0; k < n && k < n_rfw; k++) begin
        chk(int'(lg_ridx[k]) == e_idx[k], $sformatf("R2 load index[%0d] act=%0d exp=%0d", k, lg_ridx[k], e_idx[k]));
        chk(lg_rdat[k] == mem_fn(e_addr[k]), $sformatf("R6 load data[%0d] act=%h exp=%h", k, lg_rdat[k], mem_fn(e_addr[k])));
      end
    end else
      chk(n_rfw == 0, $sformatf("R6 store wrote regs act=%0d exp=0", n_rfw));
    chk(n_base == nb, $sformatf("R4 base write count act=%0d exp=%0d", n_base, nb));
    for (int k = 0; k < nb && k < n_base; k++)
      chk(lg_base[k] == e_base[k], $sformatf("R4 base[%0d] act=%h exp=%h", k, lg_base[k], e_base[k]));
    exp_br = ld && lst[15];
    chk(n_br == int'(exp_br), $sformatf("R6 branch count act=%0d exp=%0d", n_br, exp_br));
    if (exp_br && n > 0)
      chk(br_tgt == mem_fn(e_addr[0]) && br_pair,
          $sformatf("R6 branch target act=%h/%0b exp=%h/1", br_tgt, br_pair, mem_fn(e_addr[0])));
    chk(n_err == int'(!pre && wb), $sformatf("R7 err pulses act=%0d exp=%0d", n_err, !pre && wb));
    chk(n_overlap == 0 && n_holdbad == 0,
        $sformatf("R8 overlap/hold act=%0d/%0d exp=0/0", n_overlap, n_holdbad));
    if (lst == 16'h0)
      chk(done_pc == k0 + 1, $sformatf("R9 empty done cycle act=%0d exp=%0d", done_pc, k0 + 1));
  endtask

  initial begin
    #600000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7310));
    for (int i = 0; i < 16; i++) rf_model[i] = '0;
    clear_logs();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(mon_ev);
    chk(cmd_ready_o && !mem_req_valid_o && !rf_we_o && !done_o && !err_o && !branch_valid_o && !base_we_o,
        $sformatf("R1 reset state act=%0b%0b%0b%0b%0b exp=10000",
                  cmd_ready_o, mem_req_valid_o, rf_we_o, done_o, err_o));

    // directed corner cases
    run_cmd(16'h0000, 32'h0000_1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R9 empty load
    run_cmd(16'h0000, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R7 + R9 empty
    run_cmd(16'h8000, 32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R6 single pc load
    run_cmd(16'hFFFF, 32'h0000_4000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R2 full load
    run_cmd(16'hFFFF, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R3 full store down
    run_cmd(16'h8001, 32'h0000_6000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R7 illegal still runs
    run_cmd(16'h0421, 32'h0000_7000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R4 pre, no writeback
    run_cmd(16'h00F0, 32'h0000_0004, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); // R1 command while busy ignored
    run_cmd(16'h8421, 32'h0000_8000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1); // R1 busy, load

    // R10 responses outside a load wait
    clear_logs();
    @(mon_ev);
    spur = 1'b1;
    @(mon_ev);
    @(mon_ev);
    spur = 1'b0;
    @(mon_ev);
    chk(n_rfw == 0 && n_br == 0, $sformatf("R10 stray response act=%0d/%0d exp=0/0", n_rfw, n_br));

    for (int t = 0; t < 80; t++) begin
      logic [15:0] l;
      l = 16'($urandom);
      if (t % 3 == 0) l = l & 16'($urandom);
      run_cmd(l, $urandom & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule